// File: doc/BRIEF.md
# Subcode Q Capture and Serial Readout

This block takes the subcode Q channel of a CD or MD stream, one bit per frame, and gathers each 96-bit group: 80 payload bits followed by a 16-bit check word. A CRC runs over the payload as it arrives. When the group is complete, the payload and a pass/fail verdict are kept in a holding stage.

A falling edge on the load strobe moves the held group into a read register and sets a CRC-good flag. The host addresses the reader, drops its latch strobe, and sees the flag on the serial output. Each rising edge of the host serial clock then presents the next payload bit. Bytes leave in arrival order, and within each byte the least significant bit goes first.

Frame bits enter on a valid/ready stream. The block never applies back-pressure: ready stays high, and a bit is taken in every cycle in which valid is high. The upstream sync detector marks the first bit of each group with a start flag. All host strobes are plain levels, sampled on the block clock, and edges are found by comparing each level with its value one clock earlier.

Top module: `sq_capture`

## Requirements
- R1: During and after reset, `host_dout` is 0, no readout is active, and `sq_ready` is 1.
- R2: A bit is taken when `sq_valid` is 1. If `sq_start` is also 1, that bit opens a new group and any partial group is dropped. A bit with `sq_start` at 0 is ignored unless a group is open. A group closes after its 96th bit.
- R3: Group bits 0..79 are the payload and bits 80..95 are the check word, sent MSB first and sent inverted. The CRC uses x^16+x^12+x^5+1, starts at zero, and takes the payload MSB first. The flag is good (1) only when the computed CRC equals the bitwise complement of the received check word.
- R4: In a cycle where `load_n` is 0 after being 1 in the previous cycle, and no readout is active, the most recently completed group's payload and verdict are copied into the read register at that clock edge.
- R5: In a cycle where `latch_n` is 0 after being 1, with `rd_sel` at 1 and no readout active, a readout starts. From the next cycle `host_dout` shows the flag.
- R6: During a readout, each cycle where `sclk` is 1 after being 0 moves to the next bit. Output bit k (k = 0..79) is group bit 8*(k/8) + 7 - (k mod 8). After the 80th payload bit, the next rising edge ends the readout and `host_dout` returns to 0.
- R7: If `lock_err` is 1 in any cycle from a load up to and including the cycle of the latch fall that starts a readout, the flag is cleared to 0.
- R8: `lock_err` during a readout changes neither the flag nor the payload bits being sent.
- R9: A load strobe fall during a readout is held pending. It is applied in the first cycle after the readout ends, using the group held at that time.
- R10: A latch fall while `rd_sel` is 0 starts no readout. Serial clock edges outside a readout have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sq_valid | input | 1 | Frame bit present |
| sq_start | input | 1 | Bit is the first of a group |
| sq_bit | input | 1 | Subcode Q bit value |
| sq_ready | output | 1 | Always 1; the block never stalls input |
| load_n | input | 1 | Sync/load strobe, acts on its falling edge |
| lock_err | input | 1 | Receiver lock lost |
| rd_sel | input | 1 | Host address selects this reader |
| latch_n | input | 1 | Host latch strobe, acts on its falling edge |
| sclk | input | 1 | Host serial clock, acts on its rising edge |
| host_dout | output | 1 | Flag, then payload bits |

## Verification
The bench builds the block with its default 80 payload bits and 16-bit check word. With these values it covers the full 96-frame group and the per-byte bit reversal across all ten bytes. It also reaches the last-bit boundary where the readout ends, and a deferred load landing exactly one cycle after that end. A queue-based model tracks groups, restarts, lock timing and pending loads, and it is compared on every clock.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int BYTE_BITS = 8;
  localparam int BYTE_LOG  = 3;

  typedef enum logic {
    RD_IDLE  = 1'b0,
    RD_SHIFT = 1'b1
  } rd_state_e;
endpackage

// File: rtl/sq_crc_serial.sv
module sq_crc_serial #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] POLY  = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic             bit_i,
  output logic [WIDTH-1:0] crc
);
  logic [WIDTH-1:0] seed;
  logic [WIDTH-1:0] nxt;
  logic             fb;

  always_comb begin
    seed = restart ? '0 : crc;
    fb   = seed[WIDTH-1] ^ bit_i;
    nxt  = {seed[WIDTH-2:0], 1'b0} ^ (fb ? POLY[WIDTH-1:0] : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= '0;
    else if (step) crc <= nxt;
  end
endmodule

// File: rtl/sq_collect.sv
module sq_collect #(
  parameter int          DATA_BITS = 80,
  parameter int          CRC_BITS  = 16,
  parameter logic [15:0] CRC_POLY  = 16'h1021
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic                 in_bit,
  output logic [DATA_BITS-1:0] hold_data,
  output logic                 hold_ok
);
  localparam int GRP_BITS = DATA_BITS + CRC_BITS;
  localparam int CNT_W    = $clog2(GRP_BITS + 1);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(GRP_BITS - 1);
  localparam logic [CNT_W-1:0] GRP_END  = CNT_W'(GRP_BITS);

  logic                 open_q;
  logic [CNT_W-1:0]     cnt;
  logic [DATA_BITS-1:0] data_sr;
  logic [CRC_BITS-1:0]  rx_sr;
  logic [CRC_BITS-1:0]  crc;
  logic [CRC_BITS-1:0]  rx_full;
  logic                 take, in_data, last;

  assign take    = in_valid && (in_start || open_q);
  assign in_data = in_start || (cnt < DATA_END);
  assign last    = in_valid && !in_start && open_q && (cnt == LAST_POS);
  assign rx_full = {rx_sr[CRC_BITS-2:0], in_bit};

  sq_crc_serial #(.WIDTH(CRC_BITS), .POLY(CRC_POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (in_valid && in_start),
    .step    (take && in_data),
    .bit_i   (in_bit),
    .crc     (crc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      cnt       <= '0;
      data_sr   <= '0;
      rx_sr     <= '0;
      hold_data <= '0;
      hold_ok   <= 1'b0;
    end else if (take) begin
      if (in_start) begin
        cnt    <= CNT_W'(1);
        open_q <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      if (in_data) data_sr <= {data_sr[DATA_BITS-2:0], in_bit};
      else         rx_sr   <= rx_full;
      if (last) begin
        open_q    <= 1'b0;
        hold_data <= data_sr;
        hold_ok   <= (crc == ~rx_full);
      end
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= GRP_END);
  // R2
  close_chk: assert property (@(posedge clk) disable iff (!rst_n) last |=> !open_q);
endmodule

// File: rtl/sq_reader.sv
module sq_reader
  import sq_pkg::*;
#(
  parameter int DATA_BITS = 80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_BITS-1:0] hold_data,
  input  logic                 hold_ok,
  input  logic                 load_n,
  input  logic                 lock_err,
  input  logic                 rd_sel,
  input  logic                 latch_n,
  input  logic                 sclk,
  output logic                 dout
);
  localparam int IDX_W = $clog2(DATA_BITS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS);
  localparam logic [IDX_W-1:0] TOP_BYTE = IDX_W'(DATA_BITS - BYTE_BITS);

  rd_state_e            state;
  logic [IDX_W-1:0]     idx;
  logic [DATA_BITS-1:0] rd_data;
  logic                 flag, armed, pend;
  logic                 load_q, latch_q, sclk_q;
  logic                 load_fall, latch_fall, sclk_rise;
  logic                 do_load, latch_go, armed_mid, flag_mid, flag_nxt;
  logic [IDX_W-1:0]     pos, src_idx;

  assign load_fall  = load_q && !load_n;
  assign latch_fall = latch_q && !latch_n;
  assign sclk_rise  = !sclk_q && sclk;
  assign do_load    = load_fall || pend;
  assign latch_go   = latch_fall && rd_sel;

  always_comb begin
    armed_mid = armed || do_load;
    flag_mid  = do_load ? hold_ok : flag;
    flag_nxt  = (lock_err && armed_mid) ? 1'b0 : flag_mid;
  end

  always_comb begin
    pos     = idx - IDX_W'(1);
    src_idx = TOP_BYTE - {pos[IDX_W-1:BYTE_LOG], {BYTE_LOG{1'b0}}}
            + {{(IDX_W-BYTE_LOG){1'b0}}, pos[BYTE_LOG-1:0]};
  end

  always_comb begin
    if (state != RD_SHIFT) dout = 1'b0;
    else if (idx == '0)    dout = flag;
    else                   dout = rd_data[src_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RD_IDLE;
      idx     <= '0;
      rd_data <= '0;
      flag    <= 1'b0;
      armed   <= 1'b0;
      pend    <= 1'b0;
      load_q  <= 1'b1;
      latch_q <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      load_q  <= load_n;
      latch_q <= latch_n;
      sclk_q  <= sclk;
      if (state == RD_SHIFT) begin
        if (load_fall) pend <= 1'b1;
        if (sclk_rise) begin
          if (idx == IDX_LAST) state <= RD_IDLE;
          else                 idx   <= idx + IDX_W'(1);
        end
      end else begin
        if (do_load) begin
          rd_data <= hold_data;
          pend    <= 1'b0;
        end
        flag  <= flag_nxt;
        armed <= latch_go ? 1'b0 : armed_mid;
        if (latch_go) begin
          state <= RD_SHIFT;
          idx   <= '0;
        end
      end
    end
  end

  // R9
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_SHIFT && load_fall) |=> pend);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_SHIFT && $past(state) == RD_SHIFT) |-> $stable(flag));
  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_SHIFT && sclk_rise && idx != IDX_LAST) |=> (idx == $past(idx) + IDX_W'(1)));
  // R7
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_IDLE && lock_err && armed) |=> !flag);
  // R6
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_SHIFT && sclk_rise && idx == IDX_LAST) |=> !dout);
endmodule

// File: rtl/sq_capture.sv
module sq_capture #(
  parameter int          DATA_BITS = 80,
  parameter int          CRC_BITS  = 16,
  parameter logic [15:0] CRC_POLY  = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_valid,
  input  logic sq_start,
  input  logic sq_bit,
  output logic sq_ready,
  input  logic load_n,
  input  logic lock_err,
  input  logic rd_sel,
  input  logic latch_n,
  input  logic sclk,
  output logic host_dout
);
  logic [DATA_BITS-1:0] hold_data;
  logic                 hold_ok;

  assign sq_ready = 1'b1;

  sq_collect #(.DATA_BITS(DATA_BITS), .CRC_BITS(CRC_BITS), .CRC_POLY(CRC_POLY)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (sq_valid),
    .in_start  (sq_start),
    .in_bit    (sq_bit),
    .hold_data (hold_data),
    .hold_ok   (hold_ok)
  );

  sq_reader #(.DATA_BITS(DATA_BITS)) u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_data (hold_data),
    .hold_ok   (hold_ok),
    .load_n    (load_n),
    .lock_err  (lock_err),
    .rd_sel    (rd_sel),
    .latch_n   (latch_n),
    .sclk      (sclk),
    .dout      (host_dout)
  );
endmodule

// File: tb/sq_capture_tb.sv
module sq_capture_tb;
  localparam int CLK_NS = 10;
  localparam int NDATA  = 80;
  localparam int GRP    = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sq_valid = 1'b0, sq_start = 1'b0, sq_bit = 1'b0;
  logic load_n = 1'b1, lock_err = 1'b0, rd_sel = 1'b1, latch_n = 1'b1, sclk = 1'b0;
  logic sq_ready, host_dout;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  sq_capture u_dut (
    .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_start(sq_start), .sq_bit(sq_bit),
    .sq_ready(sq_ready), .load_n(load_n), .lock_err(lock_err), .rd_sel(rd_sel),
    .latch_n(latch_n), .sclk(sclk), .host_dout(host_dout)
  );

  always #(CLK_NS/2) clk = ~clk;

  // behavioural reference
  bit q[$];
  bit hold_d[NDATA];
  bit rd_d[NDATA];
  bit hold_ok, m_flag, m_armed, m_busy, m_pend, m_open;
  bit m_load_q, m_latch_q, m_sclk_q;
  int m_idx;

  function automatic bit exp_out();
    if (!m_busy) return 1'b0;
    if (m_idx == 0) return m_flag;
    return rd_d[8*((m_idx-1)/8) + 7 - ((m_idx-1)%8)];
  endfunction

  task automatic close_group();
    logic [15:0] c = '0;
    logic [15:0] rx = '0;
    for (int j = 0; j < NDATA; j++) begin
      logic fb = c[15] ^ q[j];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    for (int j = NDATA; j < GRP; j++) rx = {rx[14:0], q[j]};
    hold_ok = (c == ~rx);
    for (int j = 0; j < NDATA; j++) hold_d[j] = q[j];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int j = 0; j < NDATA; j++) begin hold_d[j] = 0; rd_d[j] = 0; end
      hold_ok = 0; m_flag = 0; m_armed = 0; m_busy = 0; m_pend = 0; m_open = 0;
      m_load_q = 1; m_latch_q = 1; m_sclk_q = 0; m_idx = 0;
    end else begin
      bit lf, tf, sr;
      lf = m_load_q && !load_n;
      tf = m_latch_q && !latch_n;
      sr = !m_sclk_q && sclk;
      if (m_busy) begin
        if (lf) m_pend = 1;
        if (sr) begin
          if (m_idx == NDATA) m_busy = 0;
          else m_idx++;
        end
      end else begin
        if (lf || m_pend) begin
          rd_d = hold_d; m_flag = hold_ok; m_armed = 1; m_pend = 0;
        end
        if (lock_err && m_armed) m_flag = 0;
        if (tf && rd_sel) begin m_busy = 1; m_idx = 0; m_armed = 0; end
      end
      if (sq_valid) begin
        if (sq_start) begin
          q.delete(); q.push_back(sq_bit); m_open = 1;
        end else if (m_open) begin
          q.push_back(sq_bit);
          if (q.size() == GRP) begin close_group(); m_open = 0; end
        end
      end
      m_load_q = load_n; m_latch_q = latch_n; m_sclk_q = sclk;
    end
    #(CLK_NS/4);
    checks++;
    if (host_dout !== exp_out() || sq_ready !== 1'b1) begin
      fails++;
      $display("FAIL %s model: dout=%b ready=%b expected dout=%b ready=1",
               cur_req, host_dout, sq_ready, exp_out());
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input logic exp, input string req);
    checks++;
    if (host_dout !== exp) begin
      fails++;
      $display("FAIL %s direct: dout=%b expected %b", req, host_dout, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input logic [NDATA-1:0] d);
    logic [15:0] c = '0;
    for (int j = 0; j < NDATA; j++) begin
      logic fb = c[15] ^ d[j];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  // d[j] is group bit j
  task automatic send_group(input logic [NDATA-1:0] d, input bit corrupt);
    logic [15:0] w;
    w = ~crc_of(d);
    if (corrupt) w[3] = ~w[3];
    for (int j = 0; j < GRP; j++) begin
      sq_valid = 1; sq_start = (j == 0);
      sq_bit = (j < NDATA) ? d[j] : w[15 - (j - NDATA)];
      tick();
      sq_valid = 0; sq_start = 0;
      tick();
    end
  endtask

  task automatic pulse_load(); load_n = 0; tick(); load_n = 1; tick(); endtask

  task automatic open_read(input logic exp_flag, input string req);
    latch_n = 0; tick(); check(exp_flag, req); latch_n = 1; tick();
  endtask

  task automatic read_data(input logic [NDATA-1:0] d, input int k0, input int k1, input string req);
    for (int k = k0; k < k1; k++) begin
      sclk = 1; tick();
      check(d[8*(k/8) + 7 - (k%8)], req);
      sclk = 0; tick();
    end
  endtask

  task automatic end_read(input string req);
    sclk = 1; tick(); check(1'b0, req); sclk = 0; tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NDATA-1:0] da, db, dc, dd, de, df, dg;
    da = {$urandom, $urandom, $urandom};
    db = {$urandom, $urandom, $urandom};
    dc = {$urandom, $urandom, $urandom};
    dd = {$urandom, $urandom, $urandom};
    de = {$urandom, $urandom, $urandom};
    df = {$urandom, $urandom, $urandom};
    dg = {$urandom, $urandom, $urandom};

    cur_req = "R1";
    repeat (4) tick();
    check(1'b0, "R1");
    rst_n = 1; tick();
    check(1'b0, "R1");

    // good group, full read, byte-wise LSB first
    cur_req = "R3"; send_group(da, 0);
    cur_req = "R4"; pulse_load();
    cur_req = "R5"; open_read(1'b1, "R5");
    cur_req = "R6"; read_data(da, 0, NDATA, "R6"); end_read("R6");

    // corrupted check word
    cur_req = "R3"; send_group(db, 1); pulse_load();
    open_read(1'b0, "R3"); read_data(db, 0, NDATA, "R3"); end_read("R3");

    // lock error between load and latch
    cur_req = "R7"; send_group(dc, 0); pulse_load();
    lock_err = 1; tick(); lock_err = 0; tick();
    open_read(1'b0, "R7"); read_data(dc, 0, 16, "R7");
    read_data(dc, 16, NDATA, "R7"); end_read("R7");

    // lock error during readout
    cur_req = "R8"; send_group(dd, 0); pulse_load();
    open_read(1'b1, "R8");
    lock_err = 1; read_data(dd, 0, NDATA, "R8"); lock_err = 0; end_read("R8");

    // load during readout is deferred
    cur_req = "R9"; send_group(de, 0); pulse_load();
    open_read(1'b1, "R9"); read_data(de, 0, 20, "R9");
    send_group(df, 1); pulse_load();
    read_data(de, 20, NDATA, "R9"); end_read("R9");
    open_read(1'b0, "R9"); read_data(df, 0, NDATA, "R9"); end_read("R9");

    // unselected latch and stray serial clocks
    cur_req = "R10"; rd_sel = 0;
    latch_n = 0; tick(); check(1'b0, "R10"); latch_n = 1; tick();
    sclk = 1; tick(); check(1'b0, "R10"); sclk = 0; tick();
    rd_sel = 1;

    // restart mid-group, and stray bits after the group closes
    cur_req = "R2";
    for (int j = 0; j < 40; j++) begin
      sq_valid = 1; sq_start = (j == 0); sq_bit = j[0]; tick();
      sq_valid = 0; sq_start = 0; tick();
    end
    send_group(dg, 0);
    for (int j = 0; j < 10; j++) begin
      sq_valid = 1; sq_bit = 1; tick(); sq_valid = 0; tick();
    end
    pulse_load();
    open_read(1'b1, "R2"); read_data(dg, 0, NDATA, "R2"); end_read("R2");

    repeat (3) tick();
    finish_run();
  end
endmodule